// File: doc/BRIEF.md
# String-Compare Decoder and Step Unit

This block takes 64-bit-mode instruction bytes one per cycle and picks out the string-compare instruction, which compares memory elements one pair at a time. While the bytes arrive it gathers their prefixes. When the opcode byte arrives it holds four decoded attributes: the element width, the pointer width, the segment of the first operand, and the repeat kind. The second operand always lives in the extra segment, so it has no output. Any byte that is neither a known prefix nor one of the two compare opcodes raises an illegal-encoding pulse and discards the prefixes gathered so far.

While an instruction is held, the surrounding pipeline fetches the two operands and presents them with the source pointer, the destination pointer, the count register and the direction flag, then requests a step. One cycle later the unit returns the subtraction flags, both moved pointers, the new count and whether a repeated compare goes on. Once a step reports that it does not continue, the instruction retires and the decoder accepts bytes again.

Top module: `strcmp_unit`

## Requirements
- R1: Opcode byte 0xA6 decodes to byte elements (elemSize code 0); instValid rises in the cycle after the opcode byte is accepted.
- R2: Opcode 0xA7 decodes to doubleword elements (code 2) with no size prefix, and to word elements (code 1) with a 0x66 prefix.
- R3: A REX byte (0x40–0x4F) with bit 3 set, placed directly before 0xA7, gives quadword elements (code 3), even when 0x66 is also present.
- R4: A REX byte followed by any legacy prefix has no effect on the decode.
- R5: A 0x67 prefix sets addr32, whatever the element size.
- R6: srcSeg reports the last segment override (0x26→0, 0x2E→1, 0x36→2, 0x3E→3, 0x64→4, 0x65→5). With no override it reports 3.
- R7: repMode reports the last repeat prefix: 0xF3→1 (repeat while equal), 0xF2→2 (repeat while not equal), none→0.
- R8: Any other byte, accepted while no instruction is held, pulses illegal for one cycle and clears the gathered prefixes.
- R9: The flags come from opA minus opB at the element width, using only the low bits of each operand. Their bit positions are: bit0 carry/borrow, bit1 even parity of the low result byte, bit2 borrow from bit 4, bit3 zero, bit4 sign, bit5 signed overflow.
- R10: An executed step moves both pointers by the element size in bytes. They move up when dirFlag is 0 and down when it is 1.
- R11: With addr32, the pointers, and the count under a repeat, wrap at 32 bits and their upper 32 bits read zero.
- R12: Under a repeat, an effective count of zero means no compare: executed=0, flags=0, outputs equal inputs and repContinue=0. Otherwise the count drops by one, and repContinue=1 when the new count is nonzero and the zero flag matches the repeat kind. Without a repeat the count passes through unchanged and repContinue=0.
- R13: Step results appear with stepDone one cycle after stepGo. A step request with no instruction held is ignored, and bytes that arrive while an instruction is held are ignored. instValid falls one cycle after a stepDone with repContinue=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | Instruction byte present |
| byteIn | input | 8 | Instruction byte |
| stepGo | input | 1 | Request one compare step |
| opA | input | 64 | First operand element (source side) |
| opB | input | 64 | Second operand element (extra-segment side) |
| rsiIn | input | 64 | Source pointer |
| rdiIn | input | 64 | Destination pointer |
| rcxIn | input | 64 | Count register |
| dirFlag | input | 1 | Direction flag |
| instValid | output | 1 | A decoded compare is held |
| elemSize | output | 2 | log2 of element bytes |
| addr32 | output | 1 | 32-bit pointer form |
| srcSeg | output | 3 | First-operand segment code |
| repMode | output | 2 | Repeat kind |
| illegal | output | 1 | Illegal-encoding pulse |
| stepDone | output | 1 | Step results valid |
| executed | output | 1 | A compare took place in this step |
| flags | output | 6 | Compare flags |
| rsiOut | output | 64 | Updated source pointer |
| rdiOut | output | 64 | Updated destination pointer |
| rcxOut | output | 64 | Updated count |
| repContinue | output | 1 | Repeated compare continues |

## Verification
Decode attributes and the illegal pulse appear one clock edge after the byte that causes them. The bench therefore drives each byte on a falling edge and reads the outputs at the next falling edge. Step results are due one edge after stepGo and are sampled at the falling edge that follows. Retirement takes one more edge, so the bench waits one further falling edge before it checks that instValid has dropped.

// File: rtl/strcmp_pkg.sv
package strcmp_pkg;
  localparam int XLEN   = 64;
  localparam int BYTE_W = 8;
  localparam int HALF   = XLEN / 2;
  localparam int FLAG_W = 6;

  localparam int F_CF = 0;
  localparam int F_PF = 1;
  localparam int F_AF = 2;
  localparam int F_ZF = 3;
  localparam int F_SF = 4;
  localparam int F_OF = 5;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_WORD = 2'd1, SZ_DWORD = 2'd2, SZ_QWORD = 2'd3} elemSize_e;
  typedef enum logic [1:0] {REP_NONE = 2'd0, REP_EQ = 2'd1, REP_NE = 2'd2} repMode_e;

  typedef struct packed {
    logic      go;
    elemSize_e size;
    logic      addr32;
    repMode_e  rep;
  } stepCtl_t;
endpackage

// File: rtl/strcmp_ctrl.sv
module strcmp_ctrl
  import strcmp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteIn,
  input  logic              stepGo,
  input  logic              doneQ,
  input  logic              contQ,
  output logic              instValid,
  output elemSize_e         elemSize,
  output logic              addr32,
  output logic [2:0]        srcSeg,
  output repMode_e          repMode,
  output logic              illegal,
  output stepCtl_t          stepCtl
);
  localparam logic [2:0] SEG_DEFAULT = 3'd3;

  logic       pOsz, pAsz, pRexW;
  logic [2:0] pSeg;
  repMode_e   pRep;
  logic       retire, accept;

  assign retire = instValid && doneQ && !contQ;
  assign accept = byteValid && !instValid;

  always_comb begin
    stepCtl.go     = stepGo && instValid && !retire;
    stepCtl.size   = elemSize;
    stepCtl.addr32 = addr32;
    stepCtl.rep    = repMode;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      instValid <= 1'b0;
      elemSize  <= SZ_BYTE;
      addr32    <= 1'b0;
      srcSeg    <= SEG_DEFAULT;
      repMode   <= REP_NONE;
      illegal   <= 1'b0;
      pOsz      <= 1'b0;
      pAsz      <= 1'b0;
      pRexW     <= 1'b0;
      pSeg      <= SEG_DEFAULT;
      pRep      <= REP_NONE;
    end else begin
      illegal <= 1'b0;
      if (retire) instValid <= 1'b0;
      if (accept) begin
        // a REX byte is only kept while nothing else follows it
        pRexW <= 1'b0;
        casez (byteIn)
          8'b0100_????: pRexW <= byteIn[3];
          8'h66: pOsz <= 1'b1;
          8'h67: pAsz <= 1'b1;
          8'h26: pSeg <= 3'd0;
          8'h2E: pSeg <= 3'd1;
          8'h36: pSeg <= 3'd2;
          8'h3E: pSeg <= 3'd3;
          8'h64: pSeg <= 3'd4;
          8'h65: pSeg <= 3'd5;
          8'hF3: pRep <= REP_EQ;
          8'hF2: pRep <= REP_NE;
          8'hA6, 8'hA7: begin
            instValid <= 1'b1;
            // REX.W outranks the operand-size prefix
            elemSize  <= !byteIn[0] ? SZ_BYTE : pRexW ? SZ_QWORD : pOsz ? SZ_WORD : SZ_DWORD;
            addr32    <= pAsz;
            srcSeg    <= pSeg;
            repMode   <= pRep;
            pOsz      <= 1'b0;
            pAsz      <= 1'b0;
            pSeg      <= SEG_DEFAULT;
            pRep      <= REP_NONE;
          end
          default: begin
            illegal <= 1'b1;
            pOsz    <= 1'b0;
            pAsz    <= 1'b0;
            pSeg    <= SEG_DEFAULT;
            pRep    <= REP_NONE;
          end
        endcase
      end
    end
  end

  assert_byte_size_R1: assert property (@(posedge clk) disable iff (!rstN)
    (accept && byteIn == 8'hA6) |=> (instValid && elemSize == SZ_BYTE));

  assert_bad_byte_R8: assert property (@(posedge clk) disable iff (!rstN)
    (accept && byteIn == 8'h90) |=> (illegal && !instValid));

  assert_go_needs_inst_R13: assert property (@(posedge clk) disable iff (!rstN)
    stepCtl.go |-> instValid);
endmodule

// File: rtl/strcmp_step.sv
module strcmp_step
  import strcmp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  stepCtl_t          ctl,
  input  logic [XLEN-1:0]   opA,
  input  logic [XLEN-1:0]   opB,
  input  logic [XLEN-1:0]   rsiIn,
  input  logic [XLEN-1:0]   rdiIn,
  input  logic [XLEN-1:0]   rcxIn,
  input  logic              dirFlag,
  output logic              stepDone,
  output logic              executed,
  output logic [FLAG_W-1:0] flags,
  output logic [XLEN-1:0]   rsiOut,
  output logic [XLEN-1:0]   rdiOut,
  output logic [XLEN-1:0]   rcxOut,
  output logic              repContinue
);
  localparam logic [XLEN-1:0] LOW_MASK = {{HALF{1'b0}}, {HALF{1'b1}}};

  logic [XLEN-1:0]   widthMask, aM, bM, diff, delta, srcStep, dstStep, cntEff, cntDec, cntNext;
  logic [XLEN-1:0]   srcNext, dstNext;
  logic              aMsb, bMsb, dMsb, isRep, skip, zfN;
  logic [FLAG_W-1:0] flagsN;
  logic              addr32Q;

  always_comb begin
    unique case (ctl.size)
      SZ_BYTE:  begin widthMask = XLEN'(8'hFF);        aMsb = opA[7];  bMsb = opB[7];  end
      SZ_WORD:  begin widthMask = XLEN'(16'hFFFF);     aMsb = opA[15]; bMsb = opB[15]; end
      SZ_DWORD: begin widthMask = LOW_MASK;            aMsb = opA[31]; bMsb = opB[31]; end
      default:  begin widthMask = '1;                  aMsb = opA[63]; bMsb = opB[63]; end
    endcase
    aM   = opA & widthMask;
    bM   = opB & widthMask;
    diff = (aM - bM) & widthMask;
    unique case (ctl.size)
      SZ_BYTE:  dMsb = diff[7];
      SZ_WORD:  dMsb = diff[15];
      SZ_DWORD: dMsb = diff[31];
      default:  dMsb = diff[63];
    endcase
    zfN            = (diff == '0);
    flagsN[F_CF]   = aM < bM;
    flagsN[F_PF]   = ~^diff[7:0];
    flagsN[F_AF]   = opA[4] ^ opB[4] ^ diff[4];
    flagsN[F_ZF]   = zfN;
    flagsN[F_SF]   = dMsb;
    flagsN[F_OF]   = (aMsb != bMsb) && (dMsb != aMsb);

    delta   = XLEN'(1) << ctl.size;
    srcStep = dirFlag ? rsiIn - delta : rsiIn + delta;
    dstStep = dirFlag ? rdiIn - delta : rdiIn + delta;
    srcNext = ctl.addr32 ? (srcStep & LOW_MASK) : srcStep;
    dstNext = ctl.addr32 ? (dstStep & LOW_MASK) : dstStep;

    cntEff  = ctl.addr32 ? (rcxIn & LOW_MASK) : rcxIn;
    isRep   = ctl.rep != REP_NONE;
    skip    = isRep && (cntEff == '0);
    cntDec  = ctl.addr32 ? ((cntEff - 1'b1) & LOW_MASK) : (cntEff - 1'b1);
    cntNext = isRep ? cntDec : rcxIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepDone    <= 1'b0;
      executed    <= 1'b0;
      flags       <= '0;
      rsiOut      <= '0;
      rdiOut      <= '0;
      rcxOut      <= '0;
      repContinue <= 1'b0;
      addr32Q     <= 1'b0;
    end else begin
      stepDone <= ctl.go;
      if (ctl.go) begin
        addr32Q <= ctl.addr32;
        if (skip) begin
          executed    <= 1'b0;
          flags       <= '0;
          rsiOut      <= rsiIn;
          rdiOut      <= rdiIn;
          rcxOut      <= rcxIn;
          repContinue <= 1'b0;
        end else begin
          executed    <= 1'b1;
          flags       <= flagsN;
          rsiOut      <= srcNext;
          rdiOut      <= dstNext;
          rcxOut      <= cntNext;
          repContinue <= isRep && (cntDec != '0) && ((ctl.rep == REP_EQ) ? zfN : !zfN);
        end
      end
    end
  end

  assert_zero_flag_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stepDone && executed && flags[F_ZF]) |-> (!flags[F_CF] && !flags[F_SF] && !flags[F_OF]));

  assert_equal_move_R10: assert property (@(posedge clk) disable iff (!rstN)
    (stepDone && executed) |->
      ((rsiOut[HALF-1:0] - $past(rsiIn[HALF-1:0])) == (rdiOut[HALF-1:0] - $past(rdiIn[HALF-1:0]))));

  assert_upper_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    (stepDone && executed && addr32Q) |-> (rsiOut[XLEN-1:HALF] == '0 && rdiOut[XLEN-1:HALF] == '0));

  assert_zero_count_R12: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.go && ctl.rep != REP_NONE && rcxIn == '0) |=> (!executed && !repContinue));
endmodule

// File: rtl/strcmp_unit.sv
module strcmp_unit
  import strcmp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        byteValid,
  input  logic [7:0]  byteIn,
  input  logic        stepGo,
  input  logic [63:0] opA,
  input  logic [63:0] opB,
  input  logic [63:0] rsiIn,
  input  logic [63:0] rdiIn,
  input  logic [63:0] rcxIn,
  input  logic        dirFlag,
  output logic        instValid,
  output logic [1:0]  elemSize,
  output logic        addr32,
  output logic [2:0]  srcSeg,
  output logic [1:0]  repMode,
  output logic        illegal,
  output logic        stepDone,
  output logic        executed,
  output logic [5:0]  flags,
  output logic [63:0] rsiOut,
  output logic [63:0] rdiOut,
  output logic [63:0] rcxOut,
  output logic        repContinue
);
  stepCtl_t  stepCtl;
  elemSize_e sizeQ;
  repMode_e  repQ;

  assign elemSize = sizeQ;
  assign repMode  = repQ;

  strcmp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteIn(byteIn), .stepGo(stepGo),
    .doneQ(stepDone), .contQ(repContinue), .instValid(instValid), .elemSize(sizeQ),
    .addr32(addr32), .srcSeg(srcSeg), .repMode(repQ), .illegal(illegal), .stepCtl(stepCtl)
  );

  strcmp_step u_step (
    .clk(clk), .rstN(rstN), .ctl(stepCtl), .opA(opA), .opB(opB), .rsiIn(rsiIn),
    .rdiIn(rdiIn), .rcxIn(rcxIn), .dirFlag(dirFlag), .stepDone(stepDone),
    .executed(executed), .flags(flags), .rsiOut(rsiOut), .rdiOut(rdiOut),
    .rcxOut(rcxOut), .repContinue(repContinue)
  );
endmodule

// File: tb/strcmp_unit_bench.sv
module strcmp_unit_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [63:0] M32 = 64'h0000_0000_FFFF_FFFF;

  logic clk = 1'b0, rstN = 1'b0, byteValid = 1'b0, stepGo = 1'b0, dirFlag = 1'b0;
  logic [7:0]  byteIn = '0;
  logic [63:0] opA = '0, opB = '0, rsiIn = '0, rdiIn = '0, rcxIn = '0;
  logic instValid, addr32, illegal, stepDone, executed, repContinue;
  logic [1:0] elemSize, repMode;
  logic [2:0] srcSeg;
  logic [5:0] flags;
  logic [63:0] rsiOut, rdiOut, rcxOut;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strcmp_unit u_strcmp_unit (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteIn(byteIn), .stepGo(stepGo),
    .opA(opA), .opB(opB), .rsiIn(rsiIn), .rdiIn(rdiIn), .rcxIn(rcxIn), .dirFlag(dirFlag),
    .instValid(instValid), .elemSize(elemSize), .addr32(addr32), .srcSeg(srcSeg),
    .repMode(repMode), .illegal(illegal), .stepDone(stepDone), .executed(executed),
    .flags(flags), .rsiOut(rsiOut), .rdiOut(rdiOut), .rcxOut(rcxOut), .repContinue(repContinue)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    byteValid = 1'b1; byteIn = b;
    @(negedge clk);
    byteValid = 1'b0;
  endtask

  task automatic expectDecode(input logic [1:0] sz, input logic a32, input logic [2:0] seg,
                              input logic [1:0] rep, input string req);
    chk(instValid == 1'b1, req, 64'(instValid), 64'd1);
    chk(elemSize == sz, req, 64'(elemSize), 64'(sz));
    chk(addr32 == a32, req, 64'(addr32), 64'(a32));
    chk(srcSeg == seg, req, 64'(srcSeg), 64'(seg));
    chk(repMode == rep, req, 64'(repMode), 64'(rep));
  endtask

  function automatic logic [63:0] wmask(input logic [1:0] sz);
    return (sz == 2'd3) ? '1 : ((64'd1 << (8 << sz)) - 64'd1);
  endfunction

  // independent flag model: borrow by magnitude compare, nibble borrow by low-nibble compare
  function automatic logic [5:0] expFlags(input logic [63:0] a, input logic [63:0] b, input logic [1:0] sz);
    int top = (8 << sz) - 1;
    logic [63:0] am = a & wmask(sz), bm = b & wmask(sz), d;
    logic [5:0] f;
    d = (am - bm) & wmask(sz);
    f[0] = am < bm;
    f[1] = ~^d[7:0];
    f[2] = am[3:0] < bm[3:0];
    f[3] = d == 64'd0;
    f[4] = d[top];
    f[5] = (am[top] != bm[top]) && (d[top] != am[top]);
    return f;
  endfunction

  task automatic doStep(input logic [1:0] sz, input logic a32, input logic [1:0] rep,
                        input logic [63:0] a, input logic [63:0] b, input logic [63:0] si,
                        input logic [63:0] di, input logic [63:0] cx, input logic df, input string req);
    logic [63:0] eCnt, eSi, eDi, eCx, st;
    logic eExe, eCont;
    logic [5:0] eF;
    eCnt = a32 ? (cx & M32) : cx;
    st = 64'd1 << sz;
    if (rep != 2'd0 && eCnt == 64'd0) begin
      eExe = 1'b0; eF = '0; eSi = si; eDi = di; eCx = cx; eCont = 1'b0;
    end else begin
      eExe = 1'b1;
      eF = expFlags(a, b, sz);
      eSi = df ? si - st : si + st;
      eDi = df ? di - st : di + st;
      if (a32) begin eSi &= M32; eDi &= M32; end
      eCx = (rep != 2'd0) ? ((eCnt - 64'd1) & (a32 ? M32 : '1)) : cx;
      eCont = (rep != 2'd0) && (eCx != 64'd0) && ((rep == 2'd1) ? eF[3] : !eF[3]);
    end
    opA = a; opB = b; rsiIn = si; rdiIn = di; rcxIn = cx; dirFlag = df; stepGo = 1'b1;
    @(negedge clk);
    stepGo = 1'b0;
    chk(stepDone == 1'b1, {req, " R13 done"}, 64'(stepDone), 64'd1);
    chk(executed == eExe, {req, " exec"}, 64'(executed), 64'(eExe));
    chk(flags == eF, {req, " R9 flags"}, 64'(flags), 64'(eF));
    chk(rsiOut == eSi, {req, " R10 src"}, rsiOut, eSi);
    chk(rdiOut == eDi, {req, " R10 dst"}, rdiOut, eDi);
    chk(rcxOut == eCx, {req, " R12 count"}, rcxOut, eCx);
    chk(repContinue == eCont, {req, " R12 cont"}, 64'(repContinue), 64'(eCont));
    if (!eCont) begin
      @(negedge clk);
      chk(instValid == 1'b0, {req, " R13 retire"}, 64'(instValid), 64'd0);
    end
  endtask

  task automatic testReset();
    chk(instValid == 1'b0 && illegal == 1'b0 && stepDone == 1'b0, "R13 reset",
        {61'd0, instValid, illegal, stepDone}, 64'd0);
  endtask

  task automatic testByteElem();
    sendByte(8'hA6);
    expectDecode(2'd0, 1'b0, 3'd3, 2'd0, "R1 byte opcode");
    chk(flags == 6'h00, "R1 idle flags", 64'(flags), 64'd0);
    doStep(2'd0, 1'b0, 2'd0, 64'hFF41, 64'h0041, 64'h1000, 64'h2000, 64'd7, 1'b0, "R1 step");
    chk(flags == 6'h0A, "R9 equal bytes", 64'(flags), 64'h0A);
  endtask

  task automatic testWordDword();
    sendByte(8'h66); sendByte(8'hA7);
    expectDecode(2'd1, 1'b0, 3'd3, 2'd0, "R2 word");
    doStep(2'd1, 1'b0, 2'd0, 64'hAAAA_0001, 64'h5555_0002, 64'h3000, 64'h4000, 64'd0, 1'b1, "R2 word step");
    sendByte(8'hA7);
    expectDecode(2'd2, 1'b0, 3'd3, 2'd0, "R2 dword");
    doStep(2'd2, 1'b0, 2'd0, 64'h1_7FFF_FFFF, 64'h0_FFFF_FFFF, 64'h10, 64'h20, 64'd5, 1'b0, "R2 dword step");
  endtask

  task automatic testRex();
    sendByte(8'h48); sendByte(8'hA7);
    expectDecode(2'd3, 1'b0, 3'd3, 2'd0, "R3 rex.w");
    doStep(2'd3, 1'b0, 2'd0, 64'h8000_0000_0000_0000, 64'd1, 64'h100, 64'h200, 64'd0, 1'b0, "R3 qword step");
    sendByte(8'h66); sendByte(8'h4F); sendByte(8'hA7);
    expectDecode(2'd3, 1'b0, 3'd3, 2'd0, "R3 rex.w over 66");
    doStep(2'd3, 1'b0, 2'd0, 64'd3, 64'd3, 64'h0, 64'h0, 64'd0, 1'b1, "R3 step down");
    sendByte(8'h48); sendByte(8'h66); sendByte(8'hA7);
    expectDecode(2'd1, 1'b0, 3'd3, 2'd0, "R4 rex then prefix");
    doStep(2'd1, 1'b0, 2'd0, 64'd5, 64'd9, 64'h8, 64'h8, 64'd0, 1'b0, "R4 step");
    sendByte(8'h40); sendByte(8'hA7);
    expectDecode(2'd2, 1'b0, 3'd3, 2'd0, "R3 rex without w");
    doStep(2'd2, 1'b0, 2'd0, 64'd1, 64'd2, 64'h8, 64'h8, 64'd0, 1'b0, "R3 rex step");
  endtask

  task automatic testAddr32();
    sendByte(8'h67); sendByte(8'h48); sendByte(8'hA7);
    expectDecode(2'd3, 1'b1, 3'd3, 2'd0, "R5 addr32 qword");
    doStep(2'd3, 1'b1, 2'd0, 64'd1, 64'd1, 64'hFFFF_FFFF_FFFF_FFFC, 64'h1234_5678_0000_0004,
           64'hDEAD_0000_0000_0009, 1'b0, "R11 wrap up");
    chk(rsiOut == 64'd4, "R11 wrapped src", rsiOut, 64'd4);
    sendByte(8'h67); sendByte(8'hA6);
    expectDecode(2'd0, 1'b1, 3'd3, 2'd0, "R5 addr32 byte");
    doStep(2'd0, 1'b1, 2'd0, 64'd2, 64'd1, 64'h0, 64'hFFFF_0000_0000_0000, 64'd0, 1'b1, "R11 wrap down");
  endtask

  task automatic testSeg();
    sendByte(8'h2E); sendByte(8'h64); sendByte(8'hA6);
    expectDecode(2'd0, 1'b0, 3'd4, 2'd0, "R6 last override");
    doStep(2'd0, 1'b0, 2'd0, 64'd0, 64'd0, 64'd0, 64'd0, 64'd0, 1'b0, "R6 step");
    sendByte(8'h26); sendByte(8'hA6);
    expectDecode(2'd0, 1'b0, 3'd0, 2'd0, "R6 es override");
    doStep(2'd0, 1'b0, 2'd0, 64'd0, 64'd0, 64'd0, 64'd0, 64'd0, 1'b0, "R6 step2");
    sendByte(8'h65); sendByte(8'hA6);
    expectDecode(2'd0, 1'b0, 3'd5, 2'd0, "R6 gs override");
    doStep(2'd0, 1'b0, 2'd0, 64'd0, 64'd0, 64'd0, 64'd0, 64'd0, 1'b0, "R6 step3");
  endtask

  task automatic testRepeat();
    sendByte(8'hF3); sendByte(8'hA6);
    expectDecode(2'd0, 1'b0, 3'd3, 2'd1, "R7 repe");
    doStep(2'd0, 1'b0, 2'd1, 64'h33, 64'h33, 64'h50, 64'h60, 64'd3, 1'b0, "R12 repe equal");
    chk(repContinue == 1'b1, "R12 repe continues", 64'(repContinue), 64'd1);
    doStep(2'd0, 1'b0, 2'd1, 64'h34, 64'h33, 64'h51, 64'h61, 64'd2, 1'b0, "R12 repe mismatch");
    sendByte(8'hF2); sendByte(8'h66); sendByte(8'hA7);
    expectDecode(2'd1, 1'b0, 3'd3, 2'd2, "R7 repne");
    doStep(2'd1, 1'b0, 2'd2, 64'd1, 64'd2, 64'h10, 64'h20, 64'd0, 1'b0, "R12 zero count");
    sendByte(8'hF2); sendByte(8'hF3); sendByte(8'hA6);
    expectDecode(2'd0, 1'b0, 3'd3, 2'd1, "R7 last rep wins");
    doStep(2'd0, 1'b0, 2'd1, 64'd1, 64'd1, 64'h10, 64'h20, 64'd1, 1'b0, "R12 count to zero");
    sendByte(8'h67); sendByte(8'hF2); sendByte(8'hA6);
    expectDecode(2'd0, 1'b1, 3'd3, 2'd2, "R11 rep addr32");
    doStep(2'd0, 1'b1, 2'd2, 64'd1, 64'd2, 64'h10, 64'h20, 64'hFFFF_FFFF_0000_0000, 1'b0, "R11 masked zero count");
    sendByte(8'h67); sendByte(8'hF2); sendByte(8'hA6);
    doStep(2'd0, 1'b1, 2'd2, 64'd1, 64'd2, 64'h10, 64'h20, 64'hABCD_0000_0000_0005, 1'b0, "R11 count wrap");
    chk(repContinue == 1'b1, "R11 repne continues", 64'(repContinue), 64'd1);
    doStep(2'd0, 1'b1, 2'd2, 64'd2, 64'd2, 64'h11, 64'h21, 64'h4, 1'b0, "R12 repne equal stops");
  endtask

  task automatic testIllegal();
    sendByte(8'h66); sendByte(8'h90);
    chk(illegal == 1'b1, "R8 pulse", 64'(illegal), 64'd1);
    chk(instValid == 1'b0, "R8 no inst", 64'(instValid), 64'd0);
    sendByte(8'hA7);
    chk(illegal == 1'b0, "R8 one cycle", 64'(illegal), 64'd0);
    expectDecode(2'd2, 1'b0, 3'd3, 2'd0, "R8 prefixes dropped");
    sendByte(8'h66); sendByte(8'hA6);
    chk(elemSize == 2'd2 && illegal == 1'b0, "R13 bytes ignored while held", 64'(elemSize), 64'd2);
    doStep(2'd2, 1'b0, 2'd0, 64'd1, 64'd1, 64'd0, 64'd0, 64'd0, 1'b0, "R13 retire");
    sendByte(8'hA7);
    expectDecode(2'd2, 1'b0, 3'd3, 2'd0, "R13 ignored prefix not kept");
    doStep(2'd2, 1'b0, 2'd0, 64'd1, 64'd1, 64'd0, 64'd0, 64'd0, 1'b0, "R13 retire2");
    stepGo = 1'b1;
    @(negedge clk);
    stepGo = 1'b0;
    chk(stepDone == 1'b0, "R13 step with no inst", 64'(stepDone), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testByteElem();
    testWordDword();
    testRex();
    testAddr32();
    testSeg();
    testRepeat();
    testIllegal();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule